// File: doc/BRIEF.md
# Memory-Hiding Privacy Command Controller

This block decodes one custom privacy command that arrives as a bit stream already separated from the air interface. It updates a small set of visibility settings that decide what a reader can see. These settings cover how many words of the identifier memory remain visible, whether the tag-ID memory is partly or wholly concealed, whether user memory is concealed, and whether the read range is reduced. The memory access logic of the tag uses these settings. A built-in region guard marks any access that touches a concealed region as a memory overrun, so a concealed region behaves as if it did not exist.

A frame is opened by `frm_start`. Its bits follow MSB first on `bit_vld`/`bit_dat`, and it is closed by `frm_end`. The protocol state machine provides the current tag state, the session handle and a CRC verdict. The controller answers with one of two strobes. `hdr_done` asks for a header reply after a successful update, and the tag stays secured. `to_arbitrate` asks the state machine to fall back to arbitrate. The new identifier length is also shown on `epc_words`, and the protocol-control word takes its length field from that output.

Top module: `privacy_cmd_ctrl`

## Requirements
- R1: After power-on reset every region is shown, `epc_words` is 6, the range is normal, and `hdr_done` and `to_arbitrate` are low.
- R2: A frame is a candidate only when it carries exactly 62 bits and its first 16 bits are E200h. Any other frame has no effect on any output.
- R3: With tag state secured (5), a matching handle and `crc_ok` high, a valid command updates the settings at the clock edge where `frm_end` is sampled. In the cycle after that edge `hdr_done` is high for one cycle and `to_arbitrate` stays low.
- R4: In the open (4) or killed (6) state a candidate frame changes no setting and raises neither strobe.
- R5: In the ready (0), arbitrate (1), reply (2) or acknowledged (3) state a candidate frame with `crc_ok` raises `to_arbitrate` for one cycle, one cycle after `frm_end`, and changes no setting.
- R6: Frame bits [42:37] form the identifier field. Bit 42 set conceals identifier words beyond the new length, and bit 42 clear shows them. Bits [41:37] give the new length in words, which appears on `epc_words`.
- R7: Frame bits [36:35] form the tag-ID code. Code 00 shows all tag-ID memory. Code 01 conceals word 2 and up (bit address 20h onward). Code 10 conceals all of it.
- R8: Frame bit 34 set conceals user memory, and bit 34 clear shows it.
- R9: Frame bits [33:32] form the range code. Code 00 selects normal, code 10 selects reduced, and code 01 inverts the current state. A power-on reset returns the range to normal.
- R10: The U bit (frame bit 43) and the two spare bits (frame bits [45:44]) have no effect on the result.
- R11: Tag-ID code 11 or range code 11 rejects the whole command. No setting changes and no strobe is raised.
- R12: `acc_overrun` is high for an access to bank 01 whose last word lies beyond word `epc_words`+1 while identifier concealment is on. It is also high for a bank 10 access that reaches a concealed tag-ID word, and for any bank 11 access while user memory is concealed. Bank 00 never overruns. A word count of 0 is treated as a single word.
- R13: In the secured state a frame with a wrong handle or with `crc_ok` low changes nothing and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| frm_start | input | 1 | Opens a new frame and clears the bit counter |
| bit_vld | input | 1 | `bit_dat` carries a frame bit this cycle |
| bit_dat | input | 1 | Frame bit, MSB first |
| frm_end | input | 1 | Closes the frame and triggers evaluation |
| crc_ok | input | 1 | CRC-16 verdict for the frame, valid with `frm_end` |
| cur_handle | input | 16 | Handle of the current session |
| tag_state | input | 3 | Tag state: 0 ready, 1 arbitrate, 2 reply, 3 acknowledged, 4 open, 5 secured, 6 killed |
| acc_bank | input | 2 | Bank of the memory access under test |
| acc_wptr | input | WPTR_W | First word of the access |
| acc_wcnt | input | WPTR_W | Word count of the access (0 counts as 1) |
| hdr_done | output | 1 | One-cycle request for a header reply |
| to_arbitrate | output | 1 | One-cycle request to move the tag to arbitrate |
| epc_words | output | 5 | Identifier length in words, also used as the length field of the protocol-control word |
| epc_hide | output | 1 | Identifier words beyond the length are concealed |
| tid_hide_upper | output | 1 | Tag-ID word 2 and up are concealed |
| tid_hide_all | output | 1 | All tag-ID memory is concealed |
| user_hide | output | 1 | User memory is concealed |
| range_reduced | output | 1 | Read range is reduced |
| acc_overrun | output | 1 | The access touches a concealed region |

## Verification
The assertions check the protocol rules on every cycle. Neither strobe appears unless a frame ended in a state that allows it, the two strobes never occur together, and the visibility settings hold still in every cycle without a header reply. They also require that accesses to concealed tag-ID or user memory always overrun and that bank 00 never does. The concrete field decoding can only be shown by the bench's scenarios. These cover the identifier length and its boundary word, the toggle sequence of the range mode, its loss at reset, rejection of reserved codes, indifference to the U bit, and rejection of frames with a wrong code, a wrong length, a wrong handle or a bad CRC.

// File: rtl/privacy_pkg.sv
package privacy_pkg;
  localparam int          CMD_BITS     = 62;
  localparam logic [15:0] CMD_CODE     = 16'hE200;
  localparam logic [4:0]  DEF_EPC_WORDS = 5'd6;

  typedef enum logic [2:0] {
    ST_READY     = 3'd0,
    ST_ARBITRATE = 3'd1,
    ST_REPLY     = 3'd2,
    ST_ACKED     = 3'd3,
    ST_OPEN      = 3'd4,
    ST_SECURED   = 3'd5,
    ST_KILLED    = 3'd6
  } tag_state_e;

  typedef struct packed {
    logic [15:0] code;
    logic [1:0]  spare;
    logic        u_bit;
    logic [5:0]  epc;
    logic [1:0]  tid;
    logic        user;
    logic [1:0]  rng;
    logic [15:0] handle;
    logic [15:0] crc;
  } priv_frame_t;

  localparam logic [1:0] TID_SHOW  = 2'b00;
  localparam logic [1:0] TID_UPPER = 2'b01;
  localparam logic [1:0] TID_ALL   = 2'b10;
  localparam logic [1:0] RNG_NORM  = 2'b00;
  localparam logic [1:0] RNG_FLIP  = 2'b01;
  localparam logic [1:0] RNG_RED   = 2'b10;
  localparam logic [1:0] CODE_RSVD = 2'b11;
endpackage

// File: rtl/priv_deframer.sv
module priv_deframer
  import privacy_pkg::*;
#(
  parameter int NBITS = CMD_BITS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_start,
  input  logic        bit_vld,
  input  logic        bit_dat,
  output priv_frame_t frame,
  output logic        len_ok
);
  localparam int CW = $clog2(NBITS + 2);
  localparam logic [CW-1:0] CNT_EXACT = CW'(NBITS);

  logic [NBITS-1:0] sr_q, sr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             sr_en;

  always_comb begin
    sr_en = bit_vld;
    sr_d  = {sr_q[NBITS-2:0], bit_dat};
    cnt_d = cnt_q;
    if (frm_start)
      cnt_d = '0;
    else if (bit_vld && (cnt_q != '1))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (sr_en) sr_q <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame  = priv_frame_t'(sr_q);
  assign len_ok = (cnt_q == CNT_EXACT);
endmodule

// File: rtl/priv_exec.sv
module priv_exec
  import privacy_pkg::*;
(
  input  priv_frame_t frame,
  input  logic        len_ok,
  input  logic        frm_end,
  input  logic        crc_ok,
  input  logic [15:0] cur_handle,
  input  logic [2:0]  tag_state,
  output logic        apply,
  output logic        arb_req
);
  logic hit, rsvd, early, unused_fields;

  always_comb begin
    hit     = frm_end && len_ok && crc_ok && (frame.code == CMD_CODE);
    rsvd    = (frame.tid == CODE_RSVD) || (frame.rng == CODE_RSVD);
    early   = (tag_state <= 3'(ST_ACKED));
    apply   = hit && (tag_state == 3'(ST_SECURED)) &&
              (frame.handle == cur_handle) && !rsvd;
    arb_req = hit && early;
  end

  assign unused_fields = ^{frame.spare, frame.u_bit, frame.crc};
endmodule

// File: rtl/priv_regs.sv
module priv_regs
  import privacy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply,
  input  logic       arb_req,
  input  logic [5:0] epc_fld,
  input  logic [1:0] tid_fld,
  input  logic       user_fld,
  input  logic [1:0] rng_fld,
  output logic       hdr_done,
  output logic       to_arbitrate,
  output logic       epc_hide,
  output logic [4:0] epc_words,
  output logic       tid_hide_upper,
  output logic       tid_hide_all,
  output logic       user_hide,
  output logic       range_reduced
);
  logic       hide_q, user_q, base_q, flip_q, done_q, arb_q;
  logic       base_d, flip_d;
  logic [4:0] len_q;
  logic [1:0] tid_q;

  always_comb begin
    base_d = base_q;
    flip_d = flip_q;
    unique case (rng_fld)
      RNG_NORM: begin base_d = 1'b0; flip_d = 1'b0;    end
      RNG_RED:  begin base_d = 1'b1; flip_d = 1'b0;    end
      RNG_FLIP: begin flip_d = ~flip_q;                end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hide_q <= 1'b0;
      len_q  <= DEF_EPC_WORDS;
      tid_q  <= TID_SHOW;
      user_q <= 1'b0;
      base_q <= 1'b0;
      flip_q <= 1'b0;
      done_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      if (apply) begin
        hide_q <= epc_fld[5];
        len_q  <= epc_fld[4:0];
        tid_q  <= tid_fld;
        user_q <= user_fld;
        base_q <= base_d;
        flip_q <= flip_d;
      end
      done_q <= apply;
      arb_q  <= arb_req;
    end
  end

  assign hdr_done       = done_q;
  assign to_arbitrate   = arb_q;
  assign epc_hide       = hide_q;
  assign epc_words      = len_q;
  assign tid_hide_upper = (tid_q == TID_UPPER);
  assign tid_hide_all   = (tid_q == TID_ALL);
  assign user_hide      = user_q;
  assign range_reduced  = base_q ^ flip_q;
endmodule

// File: rtl/priv_region_guard.sv
module priv_region_guard #(
  parameter int WPTR_W = 8
) (
  input  logic [1:0]        acc_bank,
  input  logic [WPTR_W-1:0] acc_wptr,
  input  logic [WPTR_W-1:0] acc_wcnt,
  input  logic              epc_hide,
  input  logic [4:0]        epc_words,
  input  logic              tid_hide_upper,
  input  logic              tid_hide_all,
  input  logic              user_hide,
  output logic              acc_overrun
);
  localparam int SW = WPTR_W + 1;
  localparam logic [SW-1:0] TID_FIRST_HIDDEN = SW'(2);

  logic [WPTR_W-1:0] cnt_eff;
  logic [SW-1:0]     last_word, epc_last;

  always_comb begin
    cnt_eff   = (acc_wcnt == '0) ? WPTR_W'(1) : acc_wcnt;
    last_word = {1'b0, acc_wptr} + {1'b0, cnt_eff} - SW'(1);
    epc_last  = SW'(epc_words) + SW'(1);
    unique case (acc_bank)
      2'b01:   acc_overrun = epc_hide && (last_word > epc_last);
      2'b10:   acc_overrun = tid_hide_all ||
                             (tid_hide_upper && (last_word >= TID_FIRST_HIDDEN));
      2'b11:   acc_overrun = user_hide;
      default: acc_overrun = 1'b0;
    endcase
  end
endmodule

// File: rtl/privacy_cmd_ctrl.sv
module privacy_cmd_ctrl
  import privacy_pkg::*;
#(
  parameter int WPTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              bit_vld,
  input  logic              bit_dat,
  input  logic              frm_end,
  input  logic              crc_ok,
  input  logic [15:0]       cur_handle,
  input  logic [2:0]        tag_state,
  input  logic [1:0]        acc_bank,
  input  logic [WPTR_W-1:0] acc_wptr,
  input  logic [WPTR_W-1:0] acc_wcnt,
  output logic              hdr_done,
  output logic              to_arbitrate,
  output logic [4:0]        epc_words,
  output logic              epc_hide,
  output logic              tid_hide_upper,
  output logic              tid_hide_all,
  output logic              user_hide,
  output logic              range_reduced,
  output logic              acc_overrun
);
  priv_frame_t frame;
  logic        len_ok, apply, arb_req;

  priv_deframer #(.NBITS(CMD_BITS)) u_deframer (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start),
    .bit_vld(bit_vld), .bit_dat(bit_dat),
    .frame(frame), .len_ok(len_ok)
  );

  priv_exec u_exec (
    .frame(frame), .len_ok(len_ok), .frm_end(frm_end), .crc_ok(crc_ok),
    .cur_handle(cur_handle), .tag_state(tag_state),
    .apply(apply), .arb_req(arb_req)
  );

  priv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .apply(apply), .arb_req(arb_req),
    .epc_fld(frame.epc), .tid_fld(frame.tid), .user_fld(frame.user),
    .rng_fld(frame.rng),
    .hdr_done(hdr_done), .to_arbitrate(to_arbitrate),
    .epc_hide(epc_hide), .epc_words(epc_words),
    .tid_hide_upper(tid_hide_upper), .tid_hide_all(tid_hide_all),
    .user_hide(user_hide), .range_reduced(range_reduced)
  );

  priv_region_guard #(.WPTR_W(WPTR_W)) u_guard (
    .acc_bank(acc_bank), .acc_wptr(acc_wptr), .acc_wcnt(acc_wcnt),
    .epc_hide(epc_hide), .epc_words(epc_words),
    .tid_hide_upper(tid_hide_upper), .tid_hide_all(tid_hide_all),
    .user_hide(user_hide), .acc_overrun(acc_overrun)
  );
endmodule

// File: rtl/privacy_cmd_chk.sv
module privacy_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_end,
  input logic [2:0] tag_state,
  input logic [1:0] acc_bank,
  input logic       hdr_done,
  input logic       to_arbitrate,
  input logic [4:0] epc_words,
  input logic       epc_hide,
  input logic       tid_hide_upper,
  input logic       tid_hide_all,
  input logic       user_hide,
  input logic       range_reduced,
  input logic       acc_overrun
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  done_after_secured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> past_ok && $past(frm_end) && ($past(tag_state) == 3'd5));

  // R5
  arb_after_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_arbitrate |-> past_ok && $past(frm_end) && ($past(tag_state) <= 3'd3));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_done && to_arbitrate));

  // R11
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !hdr_done) |-> $stable({epc_words, epc_hide, tid_hide_upper,
                                        tid_hide_all, user_hide, range_reduced}));

  // R7
  tid_all_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bank == 2'b10 && tid_hide_all) |-> acc_overrun);

  // R8
  user_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bank == 2'b11 && user_hide) |-> acc_overrun);

  // R12
  reserved_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bank == 2'b00) |-> !acc_overrun);
endmodule

bind privacy_cmd_ctrl privacy_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .tag_state(tag_state),
  .acc_bank(acc_bank), .hdr_done(hdr_done), .to_arbitrate(to_arbitrate),
  .epc_words(epc_words), .epc_hide(epc_hide), .tid_hide_upper(tid_hide_upper),
  .tid_hide_all(tid_hide_all), .user_hide(user_hide),
  .range_reduced(range_reduced), .acc_overrun(acc_overrun)
);

// File: tb/tb_privacy_cmd_ctrl.sv
module tb_privacy_cmd_ctrl;
  localparam int WPTR_W = 8;
  localparam logic [15:0] HND = 16'h1234;

  logic clk = 1'b0;
  logic rst_n, frm_start, bit_vld, bit_dat, frm_end, crc_ok;
  logic [15:0] cur_handle;
  logic [2:0]  tag_state;
  logic [1:0]  acc_bank;
  logic [WPTR_W-1:0] acc_wptr, acc_wcnt;
  logic hdr_done, to_arbitrate, epc_hide, tid_hide_upper, tid_hide_all;
  logic user_hide, range_reduced, acc_overrun;
  logic [4:0] epc_words;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];
  string      req_q[$];

  always #2 clk = ~clk;

  privacy_cmd_ctrl #(.WPTR_W(WPTR_W)) dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic u, logic [5:0] epc, logic [1:0] tid,
                                     logic usr, logic [1:0] rg, logic [15:0] h);
    return {2'b00, 16'hE200, 2'b00, u, epc, tid, usr, rg, h, 16'hBEEF};
  endfunction

  // driver: sends a frame and pushes the expected strobes {done, arb}
  task automatic send(logic [63:0] bits, int n, logic [1:0] exp, string req);
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(negedge clk); frm_start = 1'b1;
    @(negedge clk); frm_start = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_vld = 1'b1; bit_dat = bits[i];
      @(negedge clk);
    end
    bit_vld = 1'b0; frm_end = 1'b1;
    @(negedge clk); frm_end = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares strobes one cycle after each frame end
  always @(posedge clk) begin
    if (rst_n && frm_end) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: got %0h expected none", {hdr_done, to_arbitrate});
      end else begin
        chk(req_q.pop_front(), {30'd0, hdr_done, to_arbitrate}, {30'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic chk_set(string req, logic h, logic [4:0] l, logic tu, logic ta,
                         logic us, logic rr);
    chk(req, {22'd0, epc_hide, epc_words, tid_hide_upper, tid_hide_all, user_hide, range_reduced},
             {22'd0, h, l, tu, ta, us, rr});
  endtask

  task automatic chk_acc(string req, logic [1:0] b, int p, int c, logic exp);
    acc_bank = b; acc_wptr = WPTR_W'(p); acc_wcnt = WPTR_W'(c);
    #1;
    chk(req, {31'd0, acc_overrun}, {31'd0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_start = 0; bit_vld = 0; bit_dat = 0; frm_end = 0;
    crc_ok = 1'b1; cur_handle = HND; tag_state = 3'd5;
    acc_bank = 2'b00; acc_wptr = '0; acc_wcnt = '0;
    do_reset();
    // R1 reset state
    chk_set("R1", 0, 5'd6, 0, 0, 0, 0);
    chk("R1", {30'd0, hdr_done, to_arbitrate}, 32'd0);

    // R5 early states fall back to arbitrate
    tag_state = 3'd0;
    send(mk(0, 6'b100010, 2'b10, 1, 2'b10, HND), 62, 2'b01, "R5");
    tag_state = 3'd3;
    send(mk(0, 6'b100010, 2'b10, 1, 2'b10, HND), 62, 2'b01, "R5");
    chk_set("R5", 0, 5'd6, 0, 0, 0, 0);

    // R4 open and killed ignore
    tag_state = 3'd4;
    send(mk(0, 6'b100010, 2'b10, 1, 2'b10, HND), 62, 2'b00, "R4");
    tag_state = 3'd6;
    send(mk(0, 6'b100010, 2'b10, 1, 2'b10, HND), 62, 2'b00, "R4");
    chk_set("R4", 0, 5'd6, 0, 0, 0, 0);

    // R3/R6/R7/R8/R9 secured update
    tag_state = 3'd5;
    send(mk(0, 6'b100100, 2'b01, 1, 2'b10, HND), 62, 2'b10, "R3");
    chk_set("R6", 1, 5'd4, 1, 0, 1, 1);

    // R12 region guard
    chk_acc("R12", 2'b01, 5, 1, 0);
    chk_acc("R12", 2'b01, 6, 1, 1);
    chk_acc("R12", 2'b01, 4, 3, 1);
    chk_acc("R12", 2'b01, 5, 0, 0);
    chk_acc("R7", 2'b10, 1, 1, 0);
    chk_acc("R7", 2'b10, 2, 1, 1);
    chk_acc("R8", 2'b11, 0, 1, 1);
    chk_acc("R12", 2'b00, 9, 4, 0);

    // R9 toggle twice
    send(mk(0, 6'b100100, 2'b01, 1, 2'b01, HND), 62, 2'b10, "R9");
    chk_set("R9", 1, 5'd4, 1, 0, 1, 0);
    send(mk(0, 6'b100100, 2'b01, 1, 2'b01, HND), 62, 2'b10, "R9");
    chk_set("R9", 1, 5'd4, 1, 0, 1, 1);

    // R11 reserved codes
    send(mk(0, 6'b000111, 2'b11, 0, 2'b00, HND), 62, 2'b00, "R11");
    send(mk(0, 6'b000111, 2'b00, 0, 2'b11, HND), 62, 2'b00, "R11");
    chk_set("R11", 1, 5'd4, 1, 0, 1, 1);

    // R10 U bit and spare bits ignored
    send(mk(1, 6'b000111, 2'b10, 0, 2'b00, HND) | (64'h3 << 44), 62, 2'b10, "R10");
    chk_set("R10", 0, 5'd7, 0, 1, 0, 0);
    chk_acc("R7", 2'b10, 0, 1, 1);
    chk_acc("R6", 2'b01, 20, 1, 0);
    chk_acc("R8", 2'b11, 0, 1, 0);

    // R13 wrong handle / bad crc
    send(mk(0, 6'b100001, 2'b00, 1, 2'b10, 16'h4321), 62, 2'b00, "R13");
    crc_ok = 1'b0;
    send(mk(0, 6'b100001, 2'b00, 1, 2'b10, HND), 62, 2'b00, "R13");
    crc_ok = 1'b1;
    chk_set("R13", 0, 5'd7, 0, 1, 0, 0);

    // R2 wrong code / wrong length
    send(mk(0, 6'b100001, 2'b00, 1, 2'b10, HND) ^ (64'h1 << 46), 62, 2'b00, "R2");
    send(mk(0, 6'b100001, 2'b00, 1, 2'b10, HND) >> 1, 61, 2'b00, "R2");
    chk_set("R2", 0, 5'd7, 0, 1, 0, 0);

    // R9 toggled range lost at power-on reset
    send(mk(0, 6'b000110, 2'b00, 0, 2'b00, HND), 62, 2'b10, "R9");
    send(mk(0, 6'b000110, 2'b00, 0, 2'b01, HND), 62, 2'b10, "R9");
    chk_set("R9", 0, 5'd6, 0, 0, 0, 1);
    do_reset();
    chk_set("R9", 0, 5'd6, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule